// File: doc/BRIEF.md
# Dual-Port Two-Word Burst DDR SRAM

This block is a synthesizable, cycle-accurate model of a synchronous SRAM with separate read and write ports. The two ports share one address bus and take turns on it. The read address is sampled on the rising edge of `clk`, and the write address is sampled on the following rising edge of `clk_n`. Every address holds a pair of words. A single access moves both words as a two-beat double-data-rate burst: one beat per rising edge of each clock. Because reads and writes have their own data buses, a read and a write can be in flight in the same clock period and the buses never turn around.

The `lat2` pin selects the read latency. When it is high, the first word of a read appears two clock periods after the request edge. When it is low, the first word appears one period after the request edge. `rvalid` marks the periods that carry read data. Per-byte write enables go with each write beat, so single bytes of either word can be updated. The model is coherent: a read returns the newest contents of the pair, including a write issued on the same edge as the read.

Depth and word width are parameters. The storage is an inferred register array with no reset. Reset clears every request in flight and the output flags.

Top module: `burst2_sram`

## Requirements
- R1: A read is requested when `rd_sel_n` is low at a rising edge of `clk`, and `addr` at that edge is the read address. A write is requested when `wr_sel_n` is low at a rising edge of `clk`, and `addr` at the next rising edge of `clk_n` is the write address.
- R2: Each read returns both words of the addressed pair. Word 0 is on `rdata` from one rising edge of `clk` until the next rising edge of `clk_n`. Word 1 follows it until the next rising edge of `clk`.
- R3: With `lat2` high, word 0 of a read requested at clock edge E is on `rdata` in the period that starts at edge E+2.
- R4: With `lat2` low, word 0 of a read requested at clock edge E is on `rdata` in the period that starts at edge E+1.
- R5: `rvalid` is high for exactly the clock periods that carry a read burst. `rdata` is all zeros in every other period.
- R6: Write word 0 and its byte enables are sampled with the request at the `clk` edge. Word 1 and its enables are sampled at the next `clk_n` edge. Enable bit b is active high and covers data bits [b*BYTE_W +: BYTE_W]. A byte whose enable is low keeps its old value.
- R7: A port whose select is high at a `clk` edge ignores that period. A deselected write changes no stored data, and a deselected read produces no burst.
- R8: A read returns every write requested at or before its own request edge, including a write to the same address on the same edge and partial-byte updates. It does not return a write requested after its request edge.
- R9: A read and a write may be requested on the same edge, to the same address or to different addresses, and both complete.
- R10: While `rst` is high at a `clk` edge, `rvalid` is low and `rdata` is zero. Any read or write request sampled during reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; read address, request strobes and write beat 0 are sampled on its rising edge |
| clk_n | input | 1 | Complement of `clk`; write address and write beat 1 are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| addr | input | ADDR_W | Shared address bus: read address at `clk`, write address at `clk_n` |
| wdata | input | BYTE_W*NBYTES | Write data, one word per clock edge |
| wr_be | input | NBYTES | Active-high byte write enables for the current write beat |
| lat2 | input | 1 | Read latency select: high gives two periods, low gives one |
| rdata | output | BYTE_W*NBYTES | Read data, one word per half period; zero when not valid |
| rvalid | output | 1 | High for the periods that carry read data |

## Verification
A wrong fetch pipeline shows up at the ports within at most two periods. The burst lands one period early or late against `rvalid`, or `rdata` is nonzero in a period that carries no read. A broken forwarding path or byte merge stores or returns stale bytes. Such an error surfaces on the next read of the affected address, which the random traffic sends soon because it keeps half of its addresses in a narrow window. If the two half-period beats are swapped, the very first read burst after the swap shows both words in the wrong order.

// File: rtl/b2sram_pkg.sv
`timescale 1ns/1ps
package b2sram_pkg;

    localparam int DEF_ADDR_W = 6;
    localparam int DEF_BYTE_W = 8;
    localparam int DEF_NBYTES = 2;

    // read latency selected by the mode pin
    typedef enum logic {
        LAT_ONE = 1'b0,
        LAT_TWO = 1'b1
    } lat_mode_e;

    // which word of a pair is on the read bus
    typedef enum logic {
        BEAT_FIRST  = 1'b0,
        BEAT_SECOND = 1'b1
    } beat_e;

    // the clk-domain toggle flips at every clk rise and the clk_n-domain
    // copy catches up at every clk_n rise: unequal means first half
    function automatic beat_e beat_of(input logic p_tog, input logic n_tog);
        return (p_tog == n_tog) ? BEAT_SECOND : BEAT_FIRST;
    endfunction

endpackage

// File: rtl/b2_wr_capture.sv
`timescale 1ns/1ps
module b2_wr_capture
    import b2sram_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int BYTE_W = DEF_BYTE_W,
    parameter  int NBYTES = DEF_NBYTES,
    localparam int DATA_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              clk_n,
    input  logic              rst,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NBYTES-1:0] wr_be,
    output logic              cm_v,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_w0,
    output logic [DATA_W-1:0] cm_w1,
    output logic [NBYTES-1:0] cm_be0,
    output logic [NBYTES-1:0] cm_be1
);

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] d;
        logic [NBYTES-1:0] be;
    } wr_lo_t;

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [NBYTES-1:0] be;
    } wr_hi_t;

    wr_lo_t lo_q;
    wr_hi_t hi_q;

    // request strobe and first beat on the main clock
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else begin
            lo_q.v  <= !wr_sel_n;
            lo_q.d  <= wdata;
            lo_q.be <= wr_be;
        end
    end

    // address and second beat half a period later
    always_ff @(posedge clk_n) begin
        if (rst) begin
            hi_q <= '0;
        end else begin
            hi_q.a  <= addr;
            hi_q.d  <= wdata;
            hi_q.be <= wr_be;
        end
    end

    assign cm_v    = lo_q.v;
    assign cm_addr = hi_q.a;
    assign cm_w0   = lo_q.d;
    assign cm_w1   = hi_q.d;
    assign cm_be0  = lo_q.be;
    assign cm_be1  = hi_q.be;

endmodule

// File: rtl/b2_array.sv
`timescale 1ns/1ps
module b2_array
    import b2sram_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int BYTE_W = DEF_BYTE_W,
    parameter  int NBYTES = DEF_NBYTES,
    localparam int DATA_W = BYTE_W * NBYTES,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              cm_v,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic [DATA_W-1:0] cm_w0,
    input  logic [DATA_W-1:0] cm_w1,
    input  logic [NBYTES-1:0] cm_be0,
    input  logic [NBYTES-1:0] cm_be1,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_w0,
    output logic [DATA_W-1:0] fetch_w1
);

    logic [DATA_W-1:0] mem0 [DEPTH];
    logic [DATA_W-1:0] mem1 [DEPTH];

    logic [DATA_W-1:0] old0, old1;
    logic [DATA_W-1:0] new0, new1;
    logic              fwd_hit;

    assign old0 = mem0[cm_addr];
    assign old1 = mem1[cm_addr];

    // byte-granular merge of the pending write into the stored pair
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign new0[b*BYTE_W +: BYTE_W] = cm_be0[b] ? cm_w0[b*BYTE_W +: BYTE_W]
                                                    : old0[b*BYTE_W +: BYTE_W];
        assign new1[b*BYTE_W +: BYTE_W] = cm_be1[b] ? cm_w1[b*BYTE_W +: BYTE_W]
                                                    : old1[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (cm_v) begin
            mem0[cm_addr] <= new0;
            mem1[cm_addr] <= new1;
        end
    end

    // the write committing at this edge is forwarded to a fetch of the same pair
    assign fwd_hit = cm_v && (cm_addr == fetch_addr);

    always_comb begin
        if (fwd_hit) begin
            fetch_w0 = new0;
            fetch_w1 = new1;
        end else begin
            fetch_w0 = mem0[fetch_addr];
            fetch_w1 = mem1[fetch_addr];
        end
    end

endmodule

// File: rtl/b2_rd_pipe.sv
`timescale 1ns/1ps
module b2_rd_pipe
    import b2sram_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int BYTE_W = DEF_BYTE_W,
    parameter  int NBYTES = DEF_NBYTES,
    localparam int DATA_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              clk_n,
    input  logic              rst,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lat2,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] fetch_w0,
    input  logic [DATA_W-1:0] fetch_w1,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] a;
    } rd_req_t;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] w0;
        logic [DATA_W-1:0] w1;
    } rd_pair_t;

    rd_req_t   rq_q;
    rd_pair_t  fetched;
    rd_pair_t  s1_q;
    rd_pair_t  hold_q;
    logic      p_tog;
    logic      n_tog;
    lat_mode_e mode;
    beat_e     beat;

    assign fetch_addr = rq_q.a;
    assign mode       = lat_mode_e'(lat2);

    always_comb begin
        fetched.v  = rq_q.v;
        fetched.w0 = fetch_w0;
        fetched.w1 = fetch_w1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_q   <= '0;
            s1_q   <= '0;
            hold_q <= '0;
            p_tog  <= 1'b0;
        end else begin
            rq_q.v <= !rd_sel_n;
            rq_q.a <= addr;
            s1_q   <= fetched;
            hold_q <= (mode == LAT_TWO) ? s1_q : fetched;
            p_tog  <= !p_tog;
        end
    end

    always_ff @(posedge clk_n) begin
        if (rst) begin
            n_tog <= 1'b0;
        end else begin
            n_tog <= p_tog;
        end
    end

    assign beat   = beat_of(p_tog, n_tog);
    assign rvalid = hold_q.v;

    always_comb begin
        if (!hold_q.v) begin
            rdata = '0;
        end else if (beat == BEAT_SECOND) begin
            rdata = hold_q.w1;
        end else begin
            rdata = hold_q.w0;
        end
    end

endmodule

// File: rtl/burst2_sram.sv
`timescale 1ns/1ps
module burst2_sram
    import b2sram_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int BYTE_W = DEF_BYTE_W,
    parameter  int NBYTES = DEF_NBYTES,
    localparam int DATA_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              clk_n,
    input  logic              rst,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NBYTES-1:0] wr_be,
    input  logic              lat2,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic              cm_v;
    logic [ADDR_W-1:0] cm_addr;
    logic [DATA_W-1:0] cm_w0, cm_w1;
    logic [NBYTES-1:0] cm_be0, cm_be1;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] fetch_w0, fetch_w1;

    b2_wr_capture #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_wcap (
        .clk      (clk),
        .clk_n    (clk_n),
        .rst      (rst),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_be    (wr_be),
        .cm_v     (cm_v),
        .cm_addr  (cm_addr),
        .cm_w0    (cm_w0),
        .cm_w1    (cm_w1),
        .cm_be0   (cm_be0),
        .cm_be1   (cm_be1)
    );

    b2_array #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_array (
        .clk        (clk),
        .cm_v       (cm_v),
        .cm_addr    (cm_addr),
        .cm_w0      (cm_w0),
        .cm_w1      (cm_w1),
        .cm_be0     (cm_be0),
        .cm_be1     (cm_be1),
        .fetch_addr (fetch_addr),
        .fetch_w0   (fetch_w0),
        .fetch_w1   (fetch_w1)
    );

    b2_rd_pipe #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_rpipe (
        .clk        (clk),
        .clk_n      (clk_n),
        .rst        (rst),
        .rd_sel_n   (rd_sel_n),
        .addr       (addr),
        .lat2       (lat2),
        .fetch_addr (fetch_addr),
        .fetch_w0   (fetch_w0),
        .fetch_w1   (fetch_w1),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

endmodule

// File: rtl/burst2_sram_chk.sv
`timescale 1ns/1ps
module burst2_sram_chk (
    input logic clk,
    input logic rst,
    input logic rd_sel_n,
    input logic wr_sel_n,
    input logic lat2,
    input logic rvalid,
    input logic cm_v
);

    // edges seen since reset was released, saturating
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 3'd0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    assert_lat2_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && lat2 && $past(lat2) && $past(lat2, 2) && $past(lat2, 3))
        |-> (rvalid == $past(!rd_sel_n, 3)));

    assert_lat1_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd3 && !lat2 && !$past(lat2) && !$past(lat2, 2))
        |-> (rvalid == $past(!rd_sel_n, 2)));

    assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rvalid);

    assert_wr_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd1) |-> (cm_v == $past(!wr_sel_n)));

endmodule

bind burst2_sram burst2_sram_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_sel_n (rd_sel_n),
    .wr_sel_n (wr_sel_n),
    .lat2     (lat2),
    .rvalid   (rvalid),
    .cm_v     (cm_v)
);

// File: tb/burst2_sram_tb.sv
`timescale 1ns/1ps
module burst2_sram_tb;

    localparam int CLK_P = 20;
    localparam int AW    = 6;
    localparam int BW    = 8;
    localparam int NB    = 2;
    localparam int DW    = BW * NB;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          clk_n;
    logic          rst;
    logic          rd_sel_n, wr_sel_n, lat2;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [NB-1:0] wr_be;
    logic [DW-1:0] rdata;
    logic          rvalid;

    always #(CLK_P/2) clk = ~clk;
    assign clk_n = ~clk;

    burst2_sram #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(NB)) u_dut (
        .clk(clk), .clk_n(clk_n), .rst(rst),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr),
        .wdata(wdata), .wr_be(wr_be), .lat2(lat2),
        .rdata(rdata), .rvalid(rvalid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int edge_idx = 0;
    int lat = 2;

    logic [DW-1:0] ref0 [DEPTH];
    logic [DW-1:0] ref1 [DEPTH];
    logic          sv  [8];
    logic [DW-1:0] sw0 [8];
    logic [DW-1:0] sw1 [8];

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [NB-1:0] be);
        logic [DW-1:0] r = old_w;
        for (int b = 0; b < NB; b++)
            if (be[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Entered at 3/4 of a period; drives one request edge, checks both output halves.
    task automatic step(input bit rd, input logic [AW-1:0] ra,
                        input bit wr, input logic [AW-1:0] wa,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [NB-1:0] b0, input logic [NB-1:0] b1);
        int s;
        rd_sel_n = !rd;
        wr_sel_n = !wr;
        addr     = ra;
        wdata    = d0;
        wr_be    = b0;
        // R8: a write on the same edge is visible to the read, so apply it first
        if (wr) begin
            ref0[wa] = merge(ref0[wa], d0, b0);
            ref1[wa] = merge(ref1[wa], d1, b1);
        end
        if (rd) begin
            s = (edge_idx + 1 + lat) % 8;
            sv[s]  = 1'b1;
            sw0[s] = ref0[ra];
            sw1[s] = ref1[ra];
        end
        @(posedge clk);
        edge_idx++;
        s = edge_idx % 8;
        #(CLK_P/4);
        chk("R5 rvalid first half", DW'(rvalid), DW'(sv[s]));
        chk("R2 R3 R4 R8 word 0", rdata, sv[s] ? sw0[s] : '0);
        // R1 R6: write address and second write beat on the clk_n edge
        addr  = wa;
        wdata = d1;
        wr_be = b1;
        #(CLK_P/2);
        chk("R5 rvalid second half", DW'(rvalid), DW'(sv[s]));
        chk("R2 R6 word 1", rdata, sv[s] ? sw1[s] : '0);
        sv[s] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0, '0, '0, '0);
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            bit            rd = ($urandom % 4) != 0;
            bit            wr = ($urandom % 3) != 0;
            logic [AW-1:0] ra = ($urandom % 2) ? AW'($urandom % 4) : AW'($urandom);
            logic [AW-1:0] wa = ($urandom % 2) ? AW'($urandom % 4) : AW'($urandom);
            step(rd, ra, wr, wa, DW'($urandom), DW'($urandom), NB'($urandom), NB'($urandom));
        end
    endtask

    task automatic directed();
        // R8 R9: same-edge write and read of one pair
        step(1, 6'd9, 1, 6'd9, 16'hA1B2, 16'hC3D4, 2'b11, 2'b11);
        // R6: partial bytes, low byte of word 0 and high byte of word 1
        step(1, 6'd9, 1, 6'd9, 16'h5566, 16'h7788, 2'b01, 2'b10);
        // R8: write issued after the read must not leak into it
        step(1, 6'd9, 0, 6'd0, '0, '0, '0, '0);
        step(0, 6'd0, 1, 6'd9, 16'h1111, 16'h2222, 2'b11, 2'b11);
        step(1, 6'd9, 0, 6'd0, '0, '0, '0, '0);
        // R7: deselected write with live data and enables changes nothing
        step(0, 6'd0, 0, 6'd9, 16'hDEAD, 16'hBEEF, 2'b11, 2'b11);
        step(1, 6'd9, 0, 6'd0, '0, '0, '0, '0);
        // R9: concurrent accesses at the address extremes, back-to-back reads
        step(1, 6'd0, 1, AW'(DEPTH-1), 16'h0F0F, 16'hF0F0, 2'b11, 2'b11);
        step(1, AW'(DEPTH-1), 1, 6'd0, 16'h3C3C, 16'hC3C3, 2'b10, 2'b01);
        step(1, 6'd0, 0, 6'd0, '0, '0, '0, '0);
        idle(4);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        for (int i = 0; i < 8; i++) sv[i] = 1'b0;
        rst = 1'b1;
        rd_sel_n = 1'b0;   // R10: requests asserted during reset must be dropped
        wr_sel_n = 1'b0;
        lat2 = 1'b1;
        addr = '0;
        wdata = '0;
        wr_be = '1;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        chk("R10 rvalid in reset", DW'(rvalid), '0);
        chk("R10 rdata in reset", rdata, '0);
        #(CLK_P/2);
        rst = 1'b0;
        edge_idx = 0;
        // R10: no burst may surface from the discarded requests
        idle(3);
        // fill every pair with known data
        for (int a = 0; a < DEPTH; a++)
            step(0, '0, 1, AW'(a), DW'($urandom), DW'($urandom), 2'b11, 2'b11);
        // R3: two-period latency
        rand_run(500);
        directed();
        // R4: one-period latency
        lat = 1;
        lat2 = 1'b0;
        idle(2);
        rand_run(500);
        directed();
        lat = 2;
        lat2 = 1'b1;
        idle(2);
        directed();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule